// File: doc/BRIEF.md
# Console-to-Microcontroller Mailbox

This block sits on the cartridge bus between the console CPU and a helper microcontroller. It gives them a byte-wide, two-way exchange. The console writes a command byte into a latch. The microcontroller picks that byte up whenever it is ready and treats it as an opcode, for example directory browsing, loading a game image or dumping battery-backed RAM. The microcontroller never has to follow the console bus in real time.

In the other direction, the microcontroller drops data bytes into a return register. The console fetches them one at a time and copies them into the game SRAMs. The microcontroller also owns three controls:
- a page register that drives the upper SRAM address bits, so that the console's own address counter only has to wrap inside one page;
- a gate on the SRAM write enables;
- an active-low interrupt line that tells the console the load has finished.

Both sides share one clock. Each access is a single-cycle strobe.

Top module: `cart_mailbox`

## Requirements
- R1: After reset, both status views read 0, `irq_no` is 1, `sram_we_o` is 0 and `page_o` is 0. The status byte layout is: bit0 = command full, bit1 = return data valid, bit2 = overrun, bit3 = interrupt pending, and the upper bits read 0.
- R2: A console write at `con_addr_i`=0 latches the byte and sets the full flag. A microcontroller read at `mcu_addr_i`=0 returns that byte and clears the full flag.
- R3: A console command write that arrives while the latch is full is dropped. The latch keeps the first byte and the sticky overrun bit is set. Overrun stays set until the microcontroller writes the control register (`mcu_addr_i`=1) with bit2 = 1.
- R4: A microcontroller write at `mcu_addr_i`=0 loads the return register and sets the valid flag. A console read at `con_addr_i`=0 returns the byte and clears valid.
- R5: A console read of the return register while it is empty returns the last byte loaded, and the valid flag stays clear.
- R6: Control register bit0 written by the microcontroller drives `sram_we_o`, and the value is held until the next control write.
- R7: A microcontroller write at `mcu_addr_i`=2 loads `page_o` and can be read back there. Any write at `mcu_addr_i`=3 increments `page_o` by one, wrapping from all-ones to 0.
- R8: A control write with bit1 = 1 sets the interrupt, and `irq_no` is then held low. Only a console read of the status byte (`con_addr_i`=1) releases it. That read returns the status with bit3 set, and `irq_no` is high from the next cycle.
- R9: On simultaneous accesses, a command write against a full latch is dropped even if the microcontroller takes the latch in the same cycle. A microcontroller load of the return register wins over a console read in the same cycle, leaving valid set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| con_rd_i | input | 1 | Console read strobe |
| con_wr_i | input | 1 | Console write strobe |
| con_addr_i | input | 1 | Console register select: 0 = command/return data, 1 = status |
| con_wdata_i | input | DATA_W | Console write data |
| con_rdata_o | output | DATA_W | Console read data |
| mcu_rd_i | input | 1 | Microcontroller read strobe |
| mcu_wr_i | input | 1 | Microcontroller write strobe |
| mcu_addr_i | input | 2 | 0 = mailbox, 1 = status/control, 2 = page, 3 = page increment |
| mcu_wdata_i | input | DATA_W | Microcontroller write data |
| mcu_rdata_o | output | DATA_W | Microcontroller read data |
| page_o | output | PAGE_W | Upper SRAM address bits |
| sram_we_o | output | 1 | SRAM write-enable gate |
| irq_no | output | 1 | Interrupt request to the console, active low |

## Verification
A flag that sticks or clears at the wrong moment shows up on the very next status read from either side. A console poll loop driven by such a flag would then stall, or take a byte twice. A latch that is overwritten while full shows up as a wrong opcode on the microcontroller's next mailbox read. A lost interrupt or page update is visible on `irq_no` or `page_o` one cycle after the write that caused it. The bench therefore reads status after every transfer and checks the pins one cycle after each control write.

// File: rtl/cart_mbx_pkg.sv
package cart_mbx_pkg;
  typedef enum logic [1:0] {
    MCU_MBOX = 2'd0,
    MCU_CTRL = 2'd1,
    MCU_PAGE = 2'd2,
    MCU_PINC = 2'd3
  } mcu_reg_e;

  localparam logic CON_DATA = 1'b0;
  localparam logic CON_STAT = 1'b1;

  localparam int ST_FULL  = 0;
  localparam int ST_VALID = 1;
  localparam int ST_OVR   = 2;
  localparam int ST_IRQ   = 3;

  localparam int CT_WE  = 0;
  localparam int CT_IRQ = 1;
  localparam int CT_CLR = 2;
endpackage

// File: rtl/mbx_cmd_latch.sv
module mbx_cmd_latch #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  input  logic          clr_ovr_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          ovr_o
);
  logic [DW-1:0] data_q;
  logic          full_q, ovr_q;
  logic          accept;

  assign accept = wr_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (accept) data_q <= data_i;
      if (accept)      full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
      // set beats clear on the same edge
      if (wr_i && full_q) ovr_q <= 1'b1;
      else if (clr_ovr_i) ovr_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;

  assert_drop_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_i) |=> ($stable(data_q) && ovr_q));
  assert_ovr_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !clr_ovr_i) |=> ovr_q);
  assert_take_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !wr_i) |=> !full_q);
endmodule

// File: rtl/mbx_data_reg.sv
module mbx_data_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  logic [DW-1:0] data_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (load_i) data_q <= data_i;
      if (load_i)      valid_q <= 1'b1;
      else if (take_i) valid_q <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  assert_take_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !load_i) |=> !valid_q);
  assert_empty_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_q && !load_i) |=> ($stable(data_q) && !valid_q));
  assert_load_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_q);
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
  parameter int PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          page_ld_i,
  input  logic          page_inc_i,
  input  logic [PW-1:0] page_d_i,
  input  logic          we_wr_i,
  input  logic          we_d_i,
  input  logic          irq_set_i,
  input  logic          irq_clr_i,
  output logic [PW-1:0] page_o,
  output logic          we_o,
  output logic          irq_o
);
  logic [PW-1:0] page_q;
  logic          we_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      we_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (page_ld_i)       page_q <= page_d_i;
      else if (page_inc_i) page_q <= page_q + PW'(1);
      if (we_wr_i) we_q <= we_d_i;
      if (irq_set_i)      irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign page_o = page_q;
  assign we_o   = we_q;
  assign irq_o  = irq_q;

  assert_page_inc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_inc_i && !page_ld_i) |=> (page_q == $past(page_q) + PW'(1)));
  assert_we_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_wr_i |=> $stable(we_q));
  assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
endmodule

// File: rtl/cart_mailbox.sv
module cart_mailbox
  import cart_mbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              con_rd_i,
  input  logic              con_wr_i,
  input  logic              con_addr_i,
  input  logic [DATA_W-1:0] con_wdata_i,
  output logic [DATA_W-1:0] con_rdata_o,
  input  logic              mcu_rd_i,
  input  logic              mcu_wr_i,
  input  logic [1:0]        mcu_addr_i,
  input  logic [DATA_W-1:0] mcu_wdata_i,
  output logic [DATA_W-1:0] mcu_rdata_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              sram_we_o,
  output logic              irq_no
);
  localparam int ST_BITS = ST_IRQ + 1;

  logic              con_cmd_wr, con_data_rd, con_stat_rd;
  logic              mcu_cmd_rd, mcu_data_wr, mcu_ctrl_wr, mcu_page_wr, mcu_pinc_wr;
  logic [DATA_W-1:0] cmd_q, ret_q, status;
  logic              full, valid, ovr, irq;
  logic [PAGE_W-1:0] page;

  assign con_cmd_wr  = con_wr_i && (con_addr_i == CON_DATA);
  assign con_data_rd = con_rd_i && (con_addr_i == CON_DATA);
  assign con_stat_rd = con_rd_i && (con_addr_i == CON_STAT);
  assign mcu_cmd_rd  = mcu_rd_i && (mcu_addr_i == MCU_MBOX);
  assign mcu_data_wr = mcu_wr_i && (mcu_addr_i == MCU_MBOX);
  assign mcu_ctrl_wr = mcu_wr_i && (mcu_addr_i == MCU_CTRL);
  assign mcu_page_wr = mcu_wr_i && (mcu_addr_i == MCU_PAGE);
  assign mcu_pinc_wr = mcu_wr_i && (mcu_addr_i == MCU_PINC);

  mbx_cmd_latch #(.DW(DATA_W)) u_cmd (
    .clk_i, .rst_ni,
    .wr_i      (con_cmd_wr),
    .data_i    (con_wdata_i),
    .take_i    (mcu_cmd_rd),
    .clr_ovr_i (mcu_ctrl_wr && mcu_wdata_i[CT_CLR]),
    .data_o    (cmd_q),
    .full_o    (full),
    .ovr_o     (ovr)
  );

  mbx_data_reg #(.DW(DATA_W)) u_ret (
    .clk_i, .rst_ni,
    .load_i  (mcu_data_wr),
    .data_i  (mcu_wdata_i),
    .take_i  (con_data_rd),
    .data_o  (ret_q),
    .valid_o (valid)
  );

  mbx_ctrl #(.PW(PAGE_W)) u_ctrl (
    .clk_i, .rst_ni,
    .page_ld_i  (mcu_page_wr),
    .page_inc_i (mcu_pinc_wr),
    .page_d_i   (mcu_wdata_i[PAGE_W-1:0]),
    .we_wr_i    (mcu_ctrl_wr),
    .we_d_i     (mcu_wdata_i[CT_WE]),
    .irq_set_i  (mcu_ctrl_wr && mcu_wdata_i[CT_IRQ]),
    .irq_clr_i  (con_stat_rd),
    .page_o     (page),
    .we_o       (sram_we_o),
    .irq_o      (irq)
  );

  always_comb begin
    status = '0;
    status[ST_BITS-1:0] = {irq, ovr, valid, full};
  end

  assign con_rdata_o = con_addr_i ? status : ret_q;

  always_comb begin
    unique case (mcu_reg_e'(mcu_addr_i))
      MCU_MBOX: mcu_rdata_o = cmd_q;
      MCU_CTRL: mcu_rdata_o = status;
      MCU_PAGE: mcu_rdata_o = DATA_W'(page);
      default:  mcu_rdata_o = '0;
    endcase
  end

  assign page_o = page;
  assign irq_no = ~irq;

  assert_irq_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && con_stat_rd && !mcu_ctrl_wr) |=> irq_no);
  assert_cmd_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (con_cmd_wr && !full) |=> full);
endmodule

// File: tb/cart_mailbox_test.sv
module cart_mailbox_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       con_rd = 0, con_wr = 0, con_a = 0;
  logic [7:0] con_d = 0, con_q;
  logic       mcu_rd = 0, mcu_wr = 0;
  logic [1:0] mcu_a = 0;
  logic [7:0] mcu_d = 0, mcu_q;
  logic [4:0] page;
  logic       we, irq_n;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$], act_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  cart_mailbox uut (
    .clk_i(clk), .rst_ni(rst_n),
    .con_rd_i(con_rd), .con_wr_i(con_wr), .con_addr_i(con_a),
    .con_wdata_i(con_d), .con_rdata_o(con_q),
    .mcu_rd_i(mcu_rd), .mcu_wr_i(mcu_wr), .mcu_addr_i(mcu_a),
    .mcu_wdata_i(mcu_d), .mcu_rdata_o(mcu_q),
    .page_o(page), .sram_we_o(we), .irq_no(irq_n)
  );

  // monitor: compares queued samples against expectations
  always @(posedge clk) begin
    while (exp_q.size() > 0) begin
      logic [7:0] e, a;
      string t;
      e = exp_q.pop_front(); a = act_q.pop_front(); t = tag_q.pop_front();
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: got %02h expected %02h", t, a, e);
      end
    end
  end

  task automatic drive(bit cr, bit cw, bit ca, logic [7:0] cd,
                       bit mr, bit mw, logic [1:0] ma, logic [7:0] md);
    @(negedge clk);
    con_rd = cr; con_wr = cw; con_a = ca; con_d = cd;
    mcu_rd = mr; mcu_wr = mw; mcu_a = ma; mcu_d = md;
    #1;
  endtask

  task automatic idle(); drive(0, 0, 0, 8'h00, 0, 0, 2'd0, 8'h00); endtask

  task automatic expect_v(logic [7:0] act, logic [7:0] exp, string tag);
    exp_q.push_back(exp); act_q.push_back(act); tag_q.push_back(tag);
  endtask

  task automatic con_write(logic [7:0] d); drive(0, 1, 0, d, 0, 0, 2'd0, 8'h00); endtask
  task automatic mcu_write(logic [1:0] a, logic [7:0] d); drive(0, 0, 0, 8'h00, 0, 1, a, d); endtask
  task automatic con_read(bit a, logic [7:0] e, string t);
    drive(1, 0, a, 8'h00, 0, 0, 2'd0, 8'h00); expect_v(con_q, e, t);
  endtask
  task automatic mcu_read(logic [1:0] a, logic [7:0] e, string t);
    drive(0, 0, 0, 8'h00, 1, 0, a, 8'h00); expect_v(mcu_q, e, t);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_v({7'd0, irq_n}, 8'h01, "R1 irq_no");
    expect_v({7'd0, we}, 8'h00, "R1 sram_we");
    expect_v({3'd0, page}, 8'h00, "R1 page");
    con_read(1, 8'h00, "R1 con status");
    mcu_read(2'd1, 8'h00, "R1 mcu status");
    // R2 command path
    con_write(8'h3C);
    mcu_read(2'd1, 8'h01, "R2 full set");
    mcu_read(2'd0, 8'h3C, "R2 cmd byte");
    mcu_read(2'd1, 8'h00, "R2 full cleared");
    // R3 overrun
    con_write(8'hA5);
    con_write(8'h5A);
    mcu_read(2'd0, 8'hA5, "R3 first byte kept");
    mcu_read(2'd1, 8'h04, "R3 overrun set");
    idle();
    con_read(1, 8'h04, "R3 overrun sticky");
    mcu_write(2'd1, 8'h04);
    mcu_read(2'd1, 8'h00, "R3 overrun cleared");
    // R4/R5 return data
    mcu_write(2'd0, 8'h77);
    con_read(1, 8'h02, "R4 valid set");
    con_read(0, 8'h77, "R4 data byte");
    con_read(1, 8'h00, "R4 valid cleared");
    con_read(0, 8'h77, "R5 empty read last value");
    con_read(1, 8'h00, "R5 valid stays clear");
    // R6 write gate
    mcu_write(2'd1, 8'h01); idle();
    expect_v({7'd0, we}, 8'h01, "R6 we on");
    repeat (3) idle();
    expect_v({7'd0, we}, 8'h01, "R6 we held");
    mcu_write(2'd1, 8'h00); idle();
    expect_v({7'd0, we}, 8'h00, "R6 we off");
    // R7 page
    mcu_write(2'd2, 8'h05); idle();
    expect_v({3'd0, page}, 8'h05, "R7 page load");
    mcu_read(2'd2, 8'h05, "R7 page readback");
    mcu_write(2'd3, 8'hFF); idle();
    expect_v({3'd0, page}, 8'h06, "R7 page inc");
    mcu_write(2'd2, 8'h1F);
    mcu_write(2'd3, 8'h00); idle();
    expect_v({3'd0, page}, 8'h00, "R7 page wrap");
    // R8 interrupt
    mcu_write(2'd1, 8'h02); idle();
    expect_v({7'd0, irq_n}, 8'h00, "R8 irq asserted");
    repeat (4) idle();
    con_read(0, 8'h77, "R8 data read");
    idle();
    expect_v({7'd0, irq_n}, 8'h00, "R8 irq held");
    con_read(1, 8'h08, "R8 status shows irq");
    idle();
    expect_v({7'd0, irq_n}, 8'h01, "R8 irq released");
    // R9 simultaneous accesses
    con_write(8'h11);
    drive(0, 1, 0, 8'h22, 1, 0, 2'd0, 8'h00);
    expect_v(mcu_q, 8'h11, "R9 take during write");
    mcu_read(2'd1, 8'h04, "R9 write dropped");
    mcu_read(2'd0, 8'h11, "R9 latch unchanged");
    mcu_write(2'd1, 8'h04);
    mcu_write(2'd0, 8'h40);
    drive(1, 0, 0, 8'h00, 0, 1, 2'd0, 8'h41);
    expect_v(con_q, 8'h40, "R9 read old byte");
    con_read(1, 8'h02, "R9 load wins valid");
    con_read(0, 8'h41, "R9 new byte");
    idle(); idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule